// File: doc/BRIEF.md
# Step Attenuator Parallel Control

This block produces the 5-bit code that sets a digital step attenuator. The code is binary weighted in 1 dB steps, so its value is the loss in dB. In parallel operation the code comes from five control lines. A latch-enable input gives two behaviours:

- **Latched:** while latch enable is low, the held code stays put, and a high-then-low pulse captures the lines.
- **Direct:** while latch enable stays high, the code follows the lines.

When the mode input is high, the output carries the code from a separate serial block instead of the parallel code.

On an active-high power-on reset the block loads a defined code. If mode and latch enable are both low during reset, a 2-bit power-up select picks one of four fixed codes. If either of them is high, the code is taken from the control lines.

The mode, latch-enable and control lines are brought into the system clock through a synchroniser (`SYNC_STAGES` flops). A small state machine with the states PWRUP, HOLD and TRACK decides when the parallel register loads. The transitions are:

- PWRUP→HOLD and PWRUP→TRACK on the first clock after reset.
- HOLD→TRACK (open) when the synchronised latch enable rises.
- TRACK→HOLD (capture) when it falls.

The register loads on every cycle whose next state is TRACK.

Top module: `step_atten_ctrl`

## Requirements
- R1: With mode low and latch enable low during reset, the code after reset depends on the power-up select value {sel[1],sel[0]}: 00 gives 0, 01 gives 8, 10 gives 16 and 11 gives 31.
- R2: With latch enable high or mode high during reset, the power-up select is ignored and the parallel code after reset equals the control lines.
- R3: Output bit 4 carries the 16 dB line, bit 3 the 8 dB line, bit 2 the 4 dB line, bit 1 the 2 dB line and bit 0 the 1 dB line. All zeros is reference loss and all ones is 31 dB.
- R4: While the synchronised latch enable is low, changes on the control lines leave the parallel code unchanged.
- R5: A latch-enable pulse one clock long captures the control value present while it was high. That value is kept after latch enable returns low, even if the lines change.
- R6: With latch enable held high, a control-line change appears on the output after SYNC_STAGES+1 clock edges.
- R7: With the synchronised mode high, the output equals the serial code input, which passes without register delay. A mode change takes effect after SYNC_STAGES edges.
- R8: The parallel register keeps its normal latched and direct behaviour while serial mode is selected. Returning to parallel mode shows that parallel code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high power-on reset; the power-up code is loaded while it is high |
| mode_ser | input | 1 | 0 selects the parallel code, 1 selects the serial code |
| latch_en | input | 1 | Latch enable: high is transparent, low holds |
| ctl_lines | input | 5 | Parallel control lines, bit 4 = 16 dB through bit 0 = 1 dB |
| pup_sel | input | 2 | Power-up code select |
| ser_code | input | 5 | Code supplied by the serial block |
| atten_code | output | 5 | Attenuation code driven to the switch array |

## Verification
The bench goes after the four power-up select values and the two overrides of that table. A design with the table bits swapped, or one that ignores the override, shows the wrong code straight after reset. It drives the control lines while the latch is closed and gives one-clock latch pulses followed by an immediate line change. A latch that leaks, or that captures one cycle late, then shows the wrong value. It also walks every single-bit weight in direct mode, so a bit-order error shows up. Finally, it updates the parallel path while serial is selected. A multiplexer with the wrong select latency, or a frozen parallel register, then mismatches the per-clock model.

// File: rtl/step_atten_pkg.sv
package step_atten_pkg;

    // Parallel latch control states
    typedef enum logic [1:0] {
        LS_PWRUP = 2'd0,   // reset in progress, power-up code being loaded
        LS_HOLD  = 2'd1,   // latch closed, code held
        LS_TRACK = 2'd2    // latch open, code follows synchronised lines
    } latch_state_e;

endpackage

// File: rtl/sa_sync.sv
module sa_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // During reset every stage takes the raw value so no stale edge
    // appears when reset is released.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    stage_q[g] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stage_q[g] <= din;
                    end else begin
                        stage_q[g] <= stage_q[g-1];
                    end
                end
            end
        end
    endgenerate

    assign dout = stage_q[LAST];

endmodule

// File: rtl/sa_pwrup_decode.sv
module sa_pwrup_decode #(
    parameter int CODE_W = 5
) (
    input  logic [1:0]        sel,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_ZERO = '0;
    localparam logic [CODE_W-1:0] CODE_MID  = CODE_W'(1) << (CODE_W - 2);
    localparam logic [CODE_W-1:0] CODE_HIGH = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_MAX  = '1;

    always_comb begin
        unique case (sel)
            2'b00:   code = CODE_ZERO;
            2'b01:   code = CODE_MID;
            2'b10:   code = CODE_HIGH;
            default: code = CODE_MAX;
        endcase
    end

endmodule

// File: rtl/sa_latch_fsm.sv
module sa_latch_fsm
    import step_atten_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raw_le,
    input  logic              raw_mode,
    input  logic [CODE_W-1:0] raw_ctl,
    input  logic [CODE_W-1:0] pup_code,
    input  logic              le_s,
    input  logic [CODE_W-1:0] ctl_s,
    output logic [CODE_W-1:0] code_q,
    output latch_state_e      state_q
);
    latch_state_e state_d;
    logic         load_en;
    logic         pwr_from_lines;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LS_PWRUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_PWRUP: state_d = le_s ? LS_TRACK : LS_HOLD;
            LS_HOLD:  state_d = le_s ? LS_TRACK : LS_HOLD;   // open
            LS_TRACK: state_d = le_s ? LS_TRACK : LS_HOLD;   // capture
            default:  state_d = LS_HOLD;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        load_en = 1'b0;
        unique case (state_d)
            LS_TRACK: load_en = 1'b1;
            LS_HOLD:  load_en = 1'b0;
            LS_PWRUP: load_en = 1'b0;
            default:  load_en = 1'b0;
        endcase
    end

    assign pwr_from_lines = raw_le | raw_mode;

    // Parallel code register
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= pwr_from_lines ? raw_ctl : pup_code;
        end else if (load_en) begin
            code_q <= ctl_s;
        end
    end

endmodule

// File: rtl/sa_out_mux.sv
module sa_out_mux #(
    parameter int CODE_W = 5
) (
    input  logic              sel_ser,
    input  logic [CODE_W-1:0] par_code,
    input  logic [CODE_W-1:0] ser_code,
    output logic [CODE_W-1:0] out_code
);
    always_comb begin
        out_code = sel_ser ? ser_code : par_code;
    end

endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import step_atten_pkg::*;
#(
    parameter int CODE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_ser,
    input  logic              latch_en,
    input  logic [CODE_W-1:0] ctl_lines,
    input  logic [1:0]        pup_sel,
    input  logic [CODE_W-1:0] ser_code,
    output logic [CODE_W-1:0] atten_code
);
    localparam int BUS_W = CODE_W + 2;

    logic [BUS_W-1:0]  raw_bus;
    logic [BUS_W-1:0]  sync_bus;
    logic              mode_sync;
    logic              le_sync;
    logic [CODE_W-1:0] ctl_sync;
    logic [CODE_W-1:0] pup_code;
    logic [CODE_W-1:0] par_code;
    latch_state_e      lat_state;

    assign raw_bus = {mode_ser, latch_en, ctl_lines};
    assign {mode_sync, le_sync, ctl_sync} = sync_bus;

    sa_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_bus),
        .dout (sync_bus)
    );

    sa_pwrup_decode #(.CODE_W(CODE_W)) u_pwrup (
        .sel  (pup_sel),
        .code (pup_code)
    );

    sa_latch_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .raw_le   (latch_en),
        .raw_mode (mode_ser),
        .raw_ctl  (ctl_lines),
        .pup_code (pup_code),
        .le_s     (le_sync),
        .ctl_s    (ctl_sync),
        .code_q   (par_code),
        .state_q  (lat_state)
    );

    sa_out_mux #(.CODE_W(CODE_W)) u_mux (
        .sel_ser  (mode_sync),
        .par_code (par_code),
        .ser_code (ser_code),
        .out_code (atten_code)
    );

endmodule

// File: rtl/sa_checker.sv
module sa_checker
    import step_atten_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_ser,
    input logic              latch_en,
    input logic [CODE_W-1:0] ctl_lines,
    input logic [1:0]        pup_sel,
    input logic [CODE_W-1:0] ser_code,
    input logic [CODE_W-1:0] atten_code,
    input logic              le_s,
    input logic              mode_s,
    input logic [CODE_W-1:0] ctl_s,
    input logic [CODE_W-1:0] code_q,
    input latch_state_e      state_q
);
    function automatic logic [CODE_W-1:0] tab(input logic [1:0] s);
        case (s)
            2'b00:   tab = '0;
            2'b01:   tab = CODE_W'(8);
            2'b10:   tab = CODE_W'(16);
            default: tab = '1;
        endcase
    endfunction

    AST_PWRUP_TABLE: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && !$past(latch_en) && !$past(mode_ser)) |-> (code_q == tab($past(pup_sel)))); // R1

    AST_PWRUP_LINES: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && ($past(latch_en) || $past(mode_ser))) |-> (code_q == $past(ctl_lines))); // R2

    AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (rst)
        !le_s |=> $stable(code_q)); // R4

    AST_TRACK_OPEN: assert property (@(posedge clk) disable iff (rst)
        le_s |=> (code_q == $past(ctl_s))); // R6

    AST_SER_SELECT: assert property (@(posedge clk) disable iff (rst)
        mode_s |-> (atten_code == ser_code)); // R7

    AST_PAR_SELECT: assert property (@(posedge clk) disable iff (rst)
        !mode_s |-> (atten_code == code_q)); // R8

    AST_STATE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((state_q == LS_TRACK) == $past(le_s))); // R5

endmodule

bind step_atten_ctrl sa_checker #(.CODE_W(CODE_W)) u_sa_checker (
    .clk        (clk),
    .rst        (rst),
    .mode_ser   (mode_ser),
    .latch_en   (latch_en),
    .ctl_lines  (ctl_lines),
    .pup_sel    (pup_sel),
    .ser_code   (ser_code),
    .atten_code (atten_code),
    .le_s       (le_sync),
    .mode_s     (mode_sync),
    .ctl_s      (ctl_sync),
    .code_q     (par_code),
    .state_q    (lat_state)
);

// File: tb/step_atten_ctrl_bench.sv
module step_atten_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 5;
    localparam int S = 2;

    typedef struct packed {
        logic         le;
        logic         mode;
        logic [W-1:0] ctl;
    } samp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_ser = 1'b0;
    logic         latch_en = 1'b0;
    logic [W-1:0] ctl_lines = '0;
    logic [1:0]   pup_sel = 2'b00;
    logic [W-1:0] ser_code = '0;
    logic [W-1:0] atten_code;

    int     n_checks = 0;
    int     n_errors = 0;
    bit     started = 1'b0;
    bit     done = 1'b0;
    string  req = "R1";
    samp_t  hist[$];
    logic [W-1:0] m_code = '0;

    step_atten_ctrl #(.CODE_W(W), .SYNC_STAGES(S)) u_step_atten_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode_ser   (mode_ser),
        .latch_en   (latch_en),
        .ctl_lines  (ctl_lines),
        .pup_sel    (pup_sel),
        .ser_code   (ser_code),
        .atten_code (atten_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] pup_expect(input logic [1:0] s);
        case (s)
            2'b00:   return 5'd0;
            2'b01:   return 5'd8;
            2'b10:   return 5'd16;
            default: return 5'd31;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Behavioural reference: history of sampled inputs stands in for the
    // synchroniser delay, and the held code is a plain variable.
    always @(posedge clk) begin
        samp_t cur;
        cur = '{le: latch_en, mode: mode_ser, ctl: ctl_lines};
        if (rst) begin
            m_code = (latch_en || mode_ser) ? ctl_lines : pup_expect(pup_sel);
            hist.delete();
            for (int i = 0; i < S; i++) hist.push_back(cur);
        end else begin
            if (hist[S-1].le) m_code = hist[S-1].ctl;
            hist.push_front(cur);
            void'(hist.pop_back());
        end
        started = 1'b1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            check(req, atten_code, hist[S-1].mode ? ser_code : m_code);
        end
    end

    task automatic do_reset(input logic [1:0] p, input logic le, input logic md, input logic [W-1:0] c);
        rst = 1'b1;
        pup_sel = p;
        latch_en = le;
        mode_ser = md;
        ctl_lines = c;
        tick(4);
        rst = 1'b0;
    endtask

    initial begin
        // R1: power-up table
        for (int p = 0; p < 4; p++) begin
            req = "R1";
            do_reset(p[1:0], 1'b0, 1'b0, 5'd5);
            @(negedge clk);
            check("R1", atten_code, pup_expect(p[1:0]));
            tick(2);
        end

        // R2: latch enable high at reset takes the lines
        req = "R2";
        do_reset(2'b11, 1'b1, 1'b0, 5'd13);
        @(negedge clk);
        check("R2", atten_code, 5'd13);
        tick(3);

        // R2 / R7: serial mode at reset, output shows serial code
        req = "R7";
        ser_code = 5'd9;
        do_reset(2'b10, 1'b0, 1'b1, 5'd21);
        @(negedge clk);
        check("R7", atten_code, 5'd9);
        tick(1);
        req = "R2";
        mode_ser = 1'b0;
        tick(S + 1);
        @(negedge clk);
        check("R2", atten_code, 5'd21);

        // R4: latch closed, lines move
        req = "R4";
        for (int v = 0; v < 6; v++) begin
            tick(1);
            ctl_lines = W'(v * 7 + 1);
        end
        tick(S + 2);
        @(negedge clk);
        check("R4", atten_code, 5'd21);

        // R5: single-clock latch pulse then immediate line change
        req = "R5";
        tick(1);
        ctl_lines = 5'd6;
        latch_en = 1'b1;
        tick(1);
        latch_en = 1'b0;
        ctl_lines = 5'd25;
        tick(S + 3);
        @(negedge clk);
        check("R5", atten_code, 5'd6);

        // R6 / R3: direct mode, walk the bit weights
        req = "R6";
        tick(1);
        latch_en = 1'b1;
        foreach (pattern_list[i]) begin
            ctl_lines = pattern_list[i];
            tick(S + 1);
            @(negedge clk);
            check("R3", atten_code, pattern_list[i]);
            tick(0);
        end

        // R7: serial selected, serial code varies
        req = "R7";
        tick(1);
        mode_ser = 1'b1;
        ser_code = 5'd3;
        tick(S);
        for (int v = 0; v < 5; v++) begin
            ser_code = W'(v * 5 + 2);
            tick(1);
        end
        @(negedge clk);
        check("R7", atten_code, 5'd22);

        // R8: parallel path updates while serial is shown
        req = "R8";
        tick(1);
        ctl_lines = 5'd10;
        tick(S + 2);
        latch_en = 1'b0;
        ctl_lines = 5'd30;
        tick(S + 1);
        mode_ser = 1'b0;
        tick(S + 1);
        @(negedge clk);
        check("R8", atten_code, 5'd10);

        tick(2);
        finish_run();
    end

    logic [W-1:0] pattern_list [8] = '{5'd1, 5'd2, 5'd4, 5'd8, 5'd16, 5'd31, 5'd0, 5'd19};

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

endmodule